// File: doc/BRIEF.md
# Servo Pulse Generator with Fixed Low Time

This block drives the control pin of a continuous-rotation servo. A two-phase machine holds the pin high for a programmable number of clock cycles and then holds it low for a fixed 20 ms. After that the cycle starts again. With the 50 MHz system clock the low phase is 1,000,000 cycles. The high phase length is a raw cycle count read from a 32-bit input. Because only the low time is fixed, the pulse period changes with the high count.

Software converts a 0 to 100 speed setting into the high count with 500*speed + 50000. This gives 50,000 to 100,000 cycles (about 1.0 to 2.0 ms), and 75,000 cycles (1.5 ms) means the servo stands still. The block samples the count once per pulse, on the clock edge that ends the low phase. A new value therefore never shortens or stretches a pulse that is already in progress.

Top module: `servo_pulse_gen`

## Requirements
- R1: After synchronous reset (`rst_i` high) the machine is in the low phase with its cycle counter cleared and `servo_o` at 0. Once reset is released, `servo_o` stays low for exactly LOW_CYCLES clock cycles before the first rise.
- R2: Every low phase lasts exactly LOW_CYCLES cycles, independent of the high count. The default is 1,000,000 cycles, which is 20 ms at 50 MHz.
- R3: A high phase lasts exactly as many cycles as the count that was latched for that pulse.
- R4: `high_cycles_i` is sampled only on the clock edge that ends a low phase. A change made while the pin is high affects only the following pulse. A change made during a low phase applies to the pulse that follows that low phase.
- R5: A latched high count of zero produces a high phase of exactly one cycle, so the pin always pulses.
- R6: Counts across the full 32-bit range are accepted without truncation, including 50,000 (one end of the speed range) and 75,000 (no motion).
- R7: Asserting reset while the pin is high drives `servo_o` low on the next clock edge. After release, a complete low phase of LOW_CYCLES cycles follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (50 MHz nominal) |
| rst_i | input | 1 | Synchronous active-high reset |
| high_cycles_i | input | HIGH_W (32) | Requested high-phase length in clock cycles |
| servo_o | output | 1 | Servo control pin |

## Verification
The pin rises on the LOW_CYCLES-th rising edge after reset is released. After that it stays high for the latched number of edges and then low for LOW_CYCLES edges. A reset seen at an edge forces the pin low at that same edge. The bench samples at falling edges and counts consecutive equal samples, so each run length is measured directly in clock cycles. New counts are applied at a falling edge, either inside a high run or inside a low run. The expected width of the current pulse and of the next pulse therefore follows from which phase was active at the time of the change.

// File: rtl/servo_pwm_pkg.sv
package servo_pwm_pkg;

    localparam int unsigned CLK_HZ       = 50_000_000;
    localparam int unsigned LOW_HZ_RATIO = 50;                 // 1/50 s = 20 ms
    localparam int unsigned LOW_CYC_DEF  = CLK_HZ / LOW_HZ_RATIO;
    localparam int unsigned HIGH_W_DEF   = 32;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    function automatic phase_e phase_flip(input phase_e p);
        return (p == PH_LOW) ? PH_HIGH : PH_LOW;
    endfunction

endpackage

// File: rtl/servo_width_latch.sv
module servo_width_latch
    import servo_pwm_pkg::*;
#(
    parameter int unsigned HIGH_W = HIGH_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [HIGH_W-1:0] req_i,
    output logic [HIGH_W-1:0] width_o
);

    localparam logic [HIGH_W-1:0] ONE = HIGH_W'(1);

    logic [HIGH_W-1:0] width_q;
    logic [HIGH_W-1:0] width_d;

    // A request of zero is promoted to one cycle so a pulse is always produced.
    always_comb begin
        width_d = (req_i == '0) ? ONE : req_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            width_q <= ONE;
        end else if (load_i) begin
            width_q <= width_d;
        end
    end

    assign width_o = width_q;

endmodule

// File: rtl/servo_phase_timer.sv
module servo_phase_timer #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/servo_phase_ctrl.sv
module servo_phase_ctrl
    import servo_pwm_pkg::*;
#(
    parameter int unsigned LOW_CYCLES = LOW_CYC_DEF,
    parameter int unsigned HIGH_W     = HIGH_W_DEF,
    parameter int unsigned CNT_W      = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [HIGH_W-1:0] width_i,
    output phase_e            phase_o,
    output logic              phase_end_o,
    output logic              load_o
);

    localparam logic [CNT_W-1:0] LOW_LAST = CNT_W'(LOW_CYCLES - 1);

    phase_e phase_q;
    logic   low_last;
    logic   high_last;

    always_comb begin
        low_last    = (cnt_i == LOW_LAST);
        high_last   = (cnt_i == (CNT_W'(width_i) - CNT_W'(1)));
        phase_end_o = (phase_q == PH_LOW) ? low_last : high_last;
        load_o      = (phase_q == PH_LOW) && low_last;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_LOW;
        end else if (phase_end_o) begin
            phase_q <= phase_flip(phase_q);
        end
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/servo_pulse_gen.sv
module servo_pulse_gen
    import servo_pwm_pkg::*;
#(
    parameter int unsigned LOW_CYCLES = LOW_CYC_DEF,
    parameter int unsigned HIGH_W     = HIGH_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [HIGH_W-1:0] high_cycles_i,
    output logic              servo_o
);

    localparam int unsigned LOW_W = $clog2(LOW_CYCLES + 1);
    localparam int unsigned CNT_W = (LOW_W > HIGH_W) ? LOW_W : HIGH_W;

    logic [CNT_W-1:0]  cnt;
    logic [HIGH_W-1:0] hold_w;
    logic              phase_end;
    logic              load;
    phase_e            phase;

    servo_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (phase_end),
        .cnt_o   (cnt)
    );

    servo_width_latch #(
        .HIGH_W (HIGH_W)
    ) u_latch (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (load),
        .req_i   (high_cycles_i),
        .width_o (hold_w)
    );

    servo_phase_ctrl #(
        .LOW_CYCLES (LOW_CYCLES),
        .HIGH_W     (HIGH_W),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cnt_i       (cnt),
        .width_i     (hold_w),
        .phase_o     (phase),
        .phase_end_o (phase_end),
        .load_o      (load)
    );

    assign servo_o = (phase == PH_HIGH);

endmodule

// File: rtl/servo_pulse_gen_chk.sv
module servo_pulse_gen_chk #(
    parameter int unsigned LOW_CYCLES = 1_000_000,
    parameter int unsigned HIGH_W     = 32,
    parameter int unsigned CNT_W      = 32
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [HIGH_W-1:0] high_cycles_i,
    input logic              servo_o,
    input logic [HIGH_W-1:0] hold_w
);

    localparam logic [CNT_W-1:0] LOW_FULL = CNT_W'(LOW_CYCLES);
    localparam logic [CNT_W-1:0] LOW_LAST = CNT_W'(LOW_CYCLES - 1);

    logic [CNT_W-1:0]  low_run;
    logic [CNT_W-1:0]  high_run;
    logic [HIGH_W-1:0] exp_w;

    // Independent run-length counters observed on the output pin.
    always_ff @(posedge clk_i) begin
        if (rst_i || servo_o) low_run <= '0;
        else                  low_run <= low_run + CNT_W'(1);
        if (rst_i || !servo_o) high_run <= '0;
        else                   high_run <= high_run + CNT_W'(1);
        if (rst_i) begin
            exp_w <= HIGH_W'(1);
        end else if (!servo_o && low_run == LOW_LAST) begin
            exp_w <= (high_cycles_i == '0) ? HIGH_W'(1) : high_cycles_i;
        end
    end

    AST_RESET_LOW: assert property (@(posedge clk_i) rst_i |=> !servo_o); // R1
    AST_LOW_SPAN: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(servo_o) |-> (low_run == LOW_FULL)); // R2
    AST_HIGH_SPAN: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(servo_o) |-> (high_run == CNT_W'(exp_w))); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (servo_o && $past(servo_o)) |-> $stable(hold_w)); // R4

endmodule

bind servo_pulse_gen servo_pulse_gen_chk #(
    .LOW_CYCLES (LOW_CYCLES),
    .HIGH_W     (HIGH_W),
    .CNT_W      (CNT_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .high_cycles_i (high_cycles_i),
    .servo_o       (servo_o),
    .hold_w        (hold_w)
);

// File: tb/servo_pulse_gen_bench.sv
module servo_pulse_gen_bench;

    localparam int unsigned LOW  = 40;
    localparam int unsigned HW   = 32;
    localparam int          WDOG = 190_000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [HW-1:0] hc  = '0;
    logic          pin;

    int n_tests = 0;
    int n_fail  = 0;
    int n_cyc   = 0;

    always #2 clk = ~clk;

    servo_pulse_gen #(
        .LOW_CYCLES (LOW),
        .HIGH_W     (HW)
    ) u_servo_pulse_gen (
        .clk_i         (clk),
        .rst_i         (rst),
        .high_cycles_i (hc),
        .servo_o       (pin)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count consecutive falling-edge samples with the pin low, starting at the current one.
    task automatic run_low(output int n);
        n = 0;
        while (!pin) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_high(output int n);
        n = 0;
        while (pin) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_start();
        int n;
        hc = HW'(5);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 pin during reset", int'(pin), 0);
        rst = 1'b0;
        run_low(n);
        check("R1 first low after release", n, LOW);
    endtask

    task automatic t_basic();
        int n;
        run_high(n); check("R3 high width 5", n, 5);
        run_low(n);  check("R2 low width", n, LOW);
        run_high(n); check("R3 repeated high width 5", n, 5);
    endtask

    task automatic t_update_in_low();
        int n;
        hc = HW'(3);
        run_low(n);  check("R2 low width", n, LOW);
        run_high(n); check("R4 change in low applies to next pulse", n, 3);
    endtask

    task automatic t_update_in_high();
        int n;
        run_low(n);
        hc = HW'(9);
        run_high(n); check("R4 change in high leaves pulse unchanged", n, 3);
        run_low(n);  check("R2 low width", n, LOW);
        run_high(n); check("R4 new count on following pulse", n, 9);
    endtask

    task automatic t_zero();
        int n;
        hc = '0;
        run_low(n);
        run_high(n); check("R5 zero count gives one cycle", n, 1);
        run_low(n);  check("R2 low after one-cycle pulse", n, LOW);
    endtask

    task automatic t_nominal();
        int n;
        hc = HW'(75000);
        run_high(n); check("R5 zero count still latched", n, 1);
        run_low(n);
        run_high(n); check("R6 no-motion count 75000", n, 75000);
        hc = HW'(50000);
        run_low(n);  check("R2 low after long pulse", n, LOW);
        run_high(n); check("R6 range end count 50000", n, 50000);
    endtask

    task automatic t_mid_reset();
        int n;
        hc = HW'(20);
        run_low(n);
        repeat (4) @(negedge clk);
        check("R7 pin high before reset", int'(pin), 1);
        rst = 1'b1;
        @(negedge clk);
        check("R7 pin low one edge after reset", int'(pin), 0);
        @(negedge clk);
        rst = 1'b0;
        run_low(n);  check("R7 full low after mid-pulse reset", n, LOW);
        run_high(n); check("R3 high width 20 after reset", n, 20);
    endtask

    initial begin
        t_reset_start();
        t_basic();
        t_update_in_low();
        t_update_in_high();
        t_zero();
        t_nominal();
        t_mid_reset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            n_cyc++;
            if (n_cyc >= WDOG) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below %0d cycles", n_cyc, WDOG);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

endmodule